// File: doc/BRIEF.md
# Five-source vectored interrupt controller

This block collects interrupt requests from five sources and presents the one with the highest rank to a processor core as a single request line together with a 16-bit handler address. One source cannot be masked and is qualified by a rising edge followed by a sustained high level. One source is edge-captured and held until serviced. Two sources are level-sensitive. One source is level-sensitive and non-vectored: the core learns its handler address from outside, and the block answers it with a one-cycle acknowledge strobe.

The core steers the block with a few single-cycle commands: global enable, global disable, a mask write that also can flush the captured edge, and a status snapshot read. Raising the acknowledge input while a request is shown takes that interrupt. This drops the global enable, so a handler runs with maskable sources blocked until it enables them again. A separate combinational path turns a 3-bit restart number into its fixed restart address.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irq_o` and `ext_ack_o` are 0, the global enable is clear and all three mask bits are set, so a status read gives 8'h07.
- R2: `ien_set_i` sets the global enable and `ien_clr_i` clears it, from the next cycle. When both are high in the same cycle, the clear wins. The enable is visible as status bit 3.
- R3: The three vectored maskable sources and the non-vectored source request only while the global enable is set. A mask bit at 1 blocks its source. Mask write bits are: bit 2 for the edge source, bit 1 for level source A, bit 0 for level source B. The non-vectored source has no mask bit.
- R4: The rank is, from highest to lowest: non-maskable, edge, level A, level B, non-vectored. `vec_o` carries the address of the winner: 16'h0024, 16'h003C, 16'h0034 and 16'h002C in that order, and 16'h0000 for the non-vectored source or when nothing requests.
- R5: The level sources and the non-vectored source pass through `SYNC_STAGES` register stages. A change at the input reaches `irq_o` after `SYNC_STAGES` rising edges.
- R6: A rising edge on the edge source is captured even while that source is masked or the global enable is clear. The capture stays pending after the input falls. It is cleared when it is acknowledged as the winner, or by a mask write with bit 3 set. A new edge in the same cycle as a clear stays pending.
- R7: The non-maskable source becomes pending only after its synchronised input has been high for `NMI_HOLD` consecutive cycles following a low. It requests regardless of the enable and masks. An acknowledge clears it, and a level still held high afterwards does not request again.
- R8: `ack_i` high while `irq_o` is 1 takes the current winner and clears the global enable. `ack_i` while `irq_o` is 0 changes nothing.
- R9: When the taken winner is the non-vectored source, `ext_ack_o` is high for exactly the one cycle after the acknowledge.
- R10: `rd_i` captures a status byte into `status_o` on the next edge. Its bits are: [2:0] the masks, [3] the enable, [4] level B synchronised, [5] level A synchronised, [6] edge pending, [7] always 0.
- R11: `rvec_o` equals `rnum_i` times 8, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable source |
| edge_i | input | 1 | Edge-captured vectored source |
| lvl_a_i | input | 1 | Level vectored source A |
| lvl_b_i | input | 1 | Level vectored source B |
| ext_i | input | 1 | Level non-vectored source |
| ien_set_i | input | 1 | Global enable command |
| ien_clr_i | input | 1 | Global disable command |
| mask_wr_i | input | 1 | Mask write command |
| mask_data_i | input | 4 | Mask bits [2:0], edge flush [3] |
| rd_i | input | 1 | Status snapshot command |
| status_o | output | 8 | Captured status byte |
| ack_i | input | 1 | Core takes the shown interrupt |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | ADDR_W | Handler address of the winner |
| ext_ack_o | output | 1 | Acknowledge strobe for the non-vectored source |
| rnum_i | input | RST_NUM_W | Restart number |
| rvec_o | output | ADDR_W | Restart address |

## Verification
A level change on an input is due at `irq_o` after `SYNC_STAGES` edges. An edge capture is due one edge later than that. The non-maskable source is due `SYNC_STAGES + NMI_HOLD` edges after it rises. Commands, the status snapshot and the acknowledge strobe take effect one edge after they are driven. The restart address follows `rnum_i` in the same cycle. The bench steps a behavioural model at every rising edge, using queues of delayed inputs and a run counter. It compares all outputs at the following falling edge. Directed checks wait the stated number of edges before they sample, and also sample one edge early where the latency is the point of the check.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // Source index doubles as rank: lower index wins.
   typedef enum logic [2:0] {
      SRC_NMI  = 3'd0,
      SRC_EDGE = 3'd1,
      SRC_LA   = 3'd2,
      SRC_LB   = 3'd3,
      SRC_EXT  = 3'd4,
      SRC_NONE = 3'd7
   } irq_src_e;

   localparam int unsigned NUM_SRC   = 5;
   localparam int unsigned MSK_LB    = 0;
   localparam int unsigned MSK_LA    = 1;
   localparam int unsigned MSK_EDGE  = 2;
   localparam int unsigned MSK_FLUSH = 3;
   localparam int unsigned MSK_DW    = 4;

   typedef struct packed {
      logic       spare;
      logic       edge_pend;
      logic       la_lvl;
      logic       lb_lvl;
      logic       ien;
      logic [2:0] mask;
   } irq_stat_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("irq_sync: WIDTH must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] one_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) one_q <= '0;
         else        one_q <= d_i;
      end
      assign q_o = one_q;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
      assign q_o = sh_q[STAGES-1];
   end

endmodule

// File: rtl/irq_nmi_qual.sv
module irq_nmi_qual #(
   parameter int unsigned HOLD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic clr_i,
   output logic pend_o
);

   localparam int unsigned CW = $clog2(HOLD + 1);

   if (HOLD < 1) begin : g_bad_hold
      $error("irq_nmi_qual: HOLD must be at least 1");
   end

   logic          prev_q;
   logic          armed_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          fresh;
   logic          hit;

   always_comb begin
      fresh   = lvl_i && !prev_q;
      cnt_nxt = fresh ? CW'(1) : cnt_q + CW'(1);
      hit     = lvl_i && (fresh || armed_q) && (cnt_nxt == CW'(HOLD));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
         cnt_q   <= '0;
         pend_o  <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         if (!lvl_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else if (fresh || armed_q) begin
            armed_q <= !hit;
            cnt_q   <= cnt_nxt;
         end
         if (hit)        pend_o <= 1'b1;
         else if (clr_i) pend_o <= 1'b0;
      end
   end

   // R7
   nmi_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o) |-> $past(lvl_i));

   // R7
   nmi_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !clr_i) |=> pend_o);

endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic clr_i,
   output logic pend_o
);

   logic prev_q;
   logic rise;

   assign rise = lvl_i && !prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         if (rise)       pend_o <= 1'b1;
         else if (clr_i) pend_o <= 1'b0;
      end
   end

   // R6
   edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_i) |=> pend_o);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int unsigned         N      = 5,
   parameter int unsigned         ADDR_W = 16,
   parameter logic [N*ADDR_W-1:0] VTAB   = '0
) (
   input  logic [N-1:0]      req_i,
   output irq_src_e          win_o,
   output logic              any_o,
   output logic [ADDR_W-1:0] vec_o
);

   if (N < 1 || N > 7) begin : g_bad_n
      $error("irq_arbiter: N must be between 1 and 7");
   end

   // Walk from lowest rank upwards so the highest-ranked request overrides.
   always_comb begin
      win_o = SRC_NONE;
      vec_o = '0;
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            win_o = irq_src_e'(3'(i));
            vec_o = VTAB[i*ADDR_W +: ADDR_W];
         end
      end
      any_o = |req_i;
   end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned       ADDR_W          = 16,
   parameter int unsigned       SYNC_STAGES     = 2,
   parameter int unsigned       NMI_HOLD        = 3,
   parameter int unsigned       RST_NUM_W       = 3,
   parameter int unsigned       RST_STRIDE_LOG2 = 3,
   parameter logic [ADDR_W-1:0] VEC_NMI         = 'h0024,
   parameter logic [ADDR_W-1:0] VEC_EDGE        = 'h003C,
   parameter logic [ADDR_W-1:0] VEC_LA          = 'h0034,
   parameter logic [ADDR_W-1:0] VEC_LB          = 'h002C
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 nmi_i,
   input  logic                 edge_i,
   input  logic                 lvl_a_i,
   input  logic                 lvl_b_i,
   input  logic                 ext_i,
   input  logic                 ien_set_i,
   input  logic                 ien_clr_i,
   input  logic                 mask_wr_i,
   input  logic [MSK_DW-1:0]    mask_data_i,
   input  logic                 rd_i,
   output logic [7:0]           status_o,
   input  logic                 ack_i,
   output logic                 irq_o,
   output logic [ADDR_W-1:0]    vec_o,
   output logic                 ext_ack_o,
   input  logic [RST_NUM_W-1:0] rnum_i,
   output logic [ADDR_W-1:0]    rvec_o
);

   localparam int unsigned RV_TOP = RST_NUM_W + RST_STRIDE_LOG2;
   localparam logic [NUM_SRC*ADDR_W-1:0] VTAB =
      {{ADDR_W{1'b0}}, VEC_LB, VEC_LA, VEC_EDGE, VEC_NMI};

   if (RV_TOP > ADDR_W) begin : g_bad_rvec
      $error("irq_prio_ctrl: restart address does not fit ADDR_W");
   end
   if (RST_NUM_W < 1) begin : g_bad_rnum
      $error("irq_prio_ctrl: RST_NUM_W must be at least 1");
   end

   // ---------------- input synchronisation ----------------
   logic [NUM_SRC-1:0] raw;
   logic [NUM_SRC-1:0] syn;

   assign raw = {ext_i, lvl_b_i, lvl_a_i, edge_i, nmi_i};

   irq_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_SRC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (syn)
   );

   // ---------------- state ----------------
   logic             ien_q;
   logic [2:0]       mask_q;
   logic             ext_ack_q;
   irq_stat_t        status_q;
   logic             nmi_pend;
   logic             edge_pend;
   logic             take;
   logic             edge_clr;
   logic             nmi_clr;
   logic [NUM_SRC-1:0] req;
   irq_src_e         win;
   logic             any_req;
   logic [ADDR_W-1:0] win_vec;

   assign take     = ack_i && any_req;
   assign nmi_clr  = take && (win == SRC_NMI);
   assign edge_clr = (take && (win == SRC_EDGE)) ||
                     (mask_wr_i && mask_data_i[MSK_FLUSH]);

   irq_nmi_qual #(.HOLD(NMI_HOLD)) u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (syn[SRC_NMI]),
      .clr_i  (nmi_clr),
      .pend_o (nmi_pend)
   );

   irq_edge_latch u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (syn[SRC_EDGE]),
      .clr_i  (edge_clr),
      .pend_o (edge_pend)
   );

   // ---------------- request gating ----------------
   always_comb begin
      req           = '0;
      req[SRC_NMI]  = nmi_pend;
      req[SRC_EDGE] = ien_q && edge_pend     && !mask_q[MSK_EDGE];
      req[SRC_LA]   = ien_q && syn[SRC_LA]   && !mask_q[MSK_LA];
      req[SRC_LB]   = ien_q && syn[SRC_LB]   && !mask_q[MSK_LB];
      req[SRC_EXT]  = ien_q && syn[SRC_EXT];
   end

   irq_arbiter #(.N(NUM_SRC), .ADDR_W(ADDR_W), .VTAB(VTAB)) u_arb (
      .req_i (req),
      .win_o (win),
      .any_o (any_req),
      .vec_o (win_vec)
   );

   // ---------------- command registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q     <= 1'b0;
         mask_q    <= 3'b111;
         ext_ack_q <= 1'b0;
         status_q  <= '0;
      end else begin
         if (take || ien_clr_i) ien_q <= 1'b0;
         else if (ien_set_i)    ien_q <= 1'b1;
         if (mask_wr_i) mask_q <= mask_data_i[2:0];
         ext_ack_q <= take && (win == SRC_EXT);
         if (rd_i) begin
            status_q.spare     <= 1'b0;
            status_q.edge_pend <= edge_pend;
            status_q.la_lvl    <= syn[SRC_LA];
            status_q.lb_lvl    <= syn[SRC_LB];
            status_q.ien       <= ien_q;
            status_q.mask      <= mask_q;
         end
      end
   end

   // ---------------- outputs ----------------
   always_comb begin
      rvec_o                          = '0;
      rvec_o[RV_TOP-1:RST_STRIDE_LOG2] = rnum_i;
   end

   assign irq_o     = any_req;
   assign vec_o     = win_vec;
   assign ext_ack_o = ext_ack_q;
   assign status_o  = status_q;

   // R8
   ack_drops_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> !ien_q);

   // R2
   ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_set_i && !ien_clr_i && !(ack_i && irq_o)) |=> ien_q);

   // R3
   gated_only_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ien_q) |-> (vec_o == VEC_NMI));

   // R9
   ext_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ack_o |-> $past(ack_i));

   // R9
   ext_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ack_o |=> !ext_ack_o);

endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;

   localparam int S    = 2;
   localparam int HOLD = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi = 0, edg = 0, la = 0, lb = 0, ext = 0;
   logic        ien_set = 0, ien_clr = 0, mask_wr = 0, rd = 0, ack = 0;
   logic [3:0]  mask_data = '0;
   logic [2:0]  rnum = '0;
   logic [7:0]  status;
   logic        irq;
   logic [15:0] vec;
   logic        ext_ack;
   logic [15:0] rvec;

   always #2.5 clk = ~clk;

   irq_prio_ctrl #(.SYNC_STAGES(S), .NMI_HOLD(HOLD)) u_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .edge_i(edg), .lvl_a_i(la),
      .lvl_b_i(lb), .ext_i(ext), .ien_set_i(ien_set), .ien_clr_i(ien_clr),
      .mask_wr_i(mask_wr), .mask_data_i(mask_data), .rd_i(rd),
      .status_o(status), .ack_i(ack), .irq_o(irq), .vec_o(vec),
      .ext_ack_o(ext_ack), .rnum_i(rnum), .rvec_o(rvec)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit         q_n[$], q_e[$], q_a[$], q_b[$], q_x[$];
   bit         m_ien, m_epend, m_eprev, m_npend, m_xack;
   bit [2:0]   m_mask;
   bit [7:0]   m_stat;
   int         m_run;
   int         m_w;
   bit         m_take;

   function automatic int m_winner();
      if (m_npend) return 0;
      if (m_ien && m_epend && !m_mask[2]) return 1;
      if (m_ien && q_a[0] && !m_mask[1]) return 2;
      if (m_ien && q_b[0] && !m_mask[0]) return 3;
      if (m_ien && q_x[0]) return 4;
      return -1;
   endfunction

   function automatic logic [15:0] m_vec(int w);
      case (w)
         0: return 16'h0024;
         1: return 16'h003C;
         2: return 16'h0034;
         3: return 16'h002C;
         default: return 16'h0000;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_n = {}; q_e = {}; q_a = {}; q_b = {}; q_x = {};
         for (int i = 0; i < S; i++) begin
            q_n.push_back(0); q_e.push_back(0); q_a.push_back(0);
            q_b.push_back(0); q_x.push_back(0);
         end
         m_ien = 0; m_epend = 0; m_eprev = 0; m_npend = 0; m_xack = 0;
         m_mask = 3'b111; m_stat = 0; m_run = 0;
      end else begin
         m_w    = m_winner();
         m_take = ack && (m_w >= 0);
         if (rd) m_stat = {1'b0, m_epend, q_a[0], q_b[0], m_ien, m_mask};
         m_xack = m_take && (m_w == 4);
         // non-maskable: consecutive high run length
         m_run = q_n[0] ? m_run + 1 : 0;
         if (q_n[0] && m_run == HOLD) m_npend = 1;
         else if (m_take && m_w == 0) m_npend = 0;
         // edge capture
         if (q_e[0] && !m_eprev) m_epend = 1;
         else if ((m_take && m_w == 1) || (mask_wr && mask_data[3])) m_epend = 0;
         m_eprev = q_e[0];
         if (m_take || ien_clr) m_ien = 0;
         else if (ien_set) m_ien = 1;
         if (mask_wr) m_mask = mask_data[2:0];
         q_n.push_back(nmi); q_e.push_back(edg); q_a.push_back(la);
         q_b.push_back(lb);  q_x.push_back(ext);
         void'(q_n.pop_front()); void'(q_e.pop_front()); void'(q_a.pop_front());
         void'(q_b.pop_front()); void'(q_x.pop_front());
      end
   end

   task automatic tick();
      int w;
      @(negedge clk);
      w = m_winner();
      chk("R4 irq vs model", {31'd0, irq}, {31'd0, w >= 0});
      chk("R4 vec vs model", {16'd0, vec}, {16'd0, m_vec(w)});
      chk("R9 ext_ack vs model", {31'd0, ext_ack}, {31'd0, m_xack});
      chk("R10 status vs model", {24'd0, status}, {24'd0, m_stat});
      chk("R11 rvec vs model", {16'd0, rvec}, rnum * 8);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic pulse_rd();
      rd = 1; tick(); rd = 0;
   endtask

   task automatic wr_mask(logic [3:0] d);
      mask_wr = 1; mask_data = d; tick(); mask_wr = 0;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      ticks(3);
      rst_n = 1;
      tick();
      chk("R1 irq after reset", {31'd0, irq}, 0);
      chk("R1 ext_ack after reset", {31'd0, ext_ack}, 0);
      pulse_rd();
      chk("R1 masks set, enable clear", {24'd0, status}, 32'h07);

      ien_set = 1; tick(); ien_set = 0;
      pulse_rd();
      chk("R2 enable set", {31'd0, status[3]}, 1);
      ien_set = 1; ien_clr = 1; tick(); ien_set = 0; ien_clr = 0;
      pulse_rd();
      chk("R2 clear wins over set", {31'd0, status[3]}, 0);
      ien_set = 1; tick(); ien_set = 0;

      wr_mask(4'b0000);
      lb = 1; tick();
      chk("R5 level not yet through sync", {31'd0, irq}, 0);
      tick();
      chk("R5 level through sync", {31'd0, irq}, 1);
      chk("R4 level B vector", {16'd0, vec}, 32'h002C);
      la = 1; ticks(2);
      chk("R4 level A over B", {16'd0, vec}, 32'h0034);
      ext = 1; ticks(2);
      chk("R4 level A over non-vectored", {16'd0, vec}, 32'h0034);
      la = 0; lb = 0; ticks(2);
      chk("R4 non-vectored request", {31'd0, irq}, 1);
      chk("R4 non-vectored vector zero", {16'd0, vec}, 0);
      ack = 1; tick(); ack = 0;
      chk("R9 strobe after ack", {31'd0, ext_ack}, 1);
      chk("R8 ack drops enable", {31'd0, irq}, 0);
      tick();
      chk("R9 strobe one cycle", {31'd0, ext_ack}, 0);
      ext = 0; ticks(2);

      ien_set = 1; tick(); ien_set = 0;
      wr_mask(4'b0010);
      la = 1; ticks(3);
      chk("R3 masked level A", {31'd0, irq}, 0);
      wr_mask(4'b0000);
      chk("R3 unmasked level A", {31'd0, irq}, 1);
      chk("R3 unmasked vector", {16'd0, vec}, 32'h0034);
      ien_clr = 1; tick(); ien_clr = 0;
      chk("R3 disabled blocks", {31'd0, irq}, 0);
      la = 0; ticks(2);

      edg = 1; tick(); edg = 0; ticks(3);
      pulse_rd();
      chk("R6 captured while disabled", {31'd0, status[6]}, 1);
      ien_set = 1; tick(); ien_set = 0;
      chk("R6 pending edge requests", {16'd0, vec}, 32'h003C);
      chk("R6 pending edge irq", {31'd0, irq}, 1);
      ack = 1; tick(); ack = 0;
      ien_set = 1; tick(); ien_set = 0;
      chk("R6 ack clears edge", {31'd0, irq}, 0);
      edg = 1; tick(); edg = 0; ticks(3);
      chk("R6 second edge", {16'd0, vec}, 32'h003C);
      wr_mask(4'b1000);
      chk("R6 flush by mask write", {31'd0, irq}, 0);

      ien_clr = 1; tick(); ien_clr = 0;
      nmi = 1; ticks(2); nmi = 0; ticks(4);
      chk("R7 short pulse ignored", {31'd0, irq}, 0);
      nmi = 1; ticks(S + HOLD - 1);
      chk("R7 not yet qualified", {31'd0, irq}, 0);
      tick();
      chk("R7 qualified while disabled", {31'd0, irq}, 1);
      chk("R7 vector", {16'd0, vec}, 32'h0024);
      ack = 1; tick(); ack = 0;
      chk("R7 ack clears", {31'd0, irq}, 0);
      ticks(5);
      chk("R7 held level no repeat", {31'd0, irq}, 0);
      nmi = 0; ticks(3);

      ien_set = 1; tick(); ien_set = 0;
      ack = 1; tick(); ack = 0;
      pulse_rd();
      chk("R8 idle ack keeps enable", {31'd0, status[3]}, 1);

      for (int n = 0; n < 8; n++) begin
         rnum = 3'(n); tick();
         chk("R11 restart address", {16'd0, rvec}, n * 8);
      end

      for (int c = 0; c < 3000; c++) begin
         if ($urandom_range(0, 7) == 0)  la  = ~la;
         if ($urandom_range(0, 7) == 0)  lb  = ~lb;
         if ($urandom_range(0, 9) == 0)  ext = ~ext;
         if ($urandom_range(0, 5) == 0)  edg = ~edg;
         if ($urandom_range(0, 11) == 0) nmi = ~nmi;
         ack       = ($urandom_range(0, 3) == 0);
         ien_set   = ($urandom_range(0, 5) == 0);
         ien_clr   = ($urandom_range(0, 15) == 0);
         mask_wr   = ($urandom_range(0, 15) == 0);
         mask_data = 4'($urandom_range(0, 15));
         rd        = ($urandom_range(0, 3) == 0);
         rnum      = 3'($urandom_range(0, 7));
         tick();
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule